// File: doc/BRIEF.md
# Programmable Read Latency Pipeline

This block reproduces the read-data timing path of a synchronous graphics memory. A read command is registered on a clock edge together with a start address. The programmed latency (1, 2 or 3 clocks), burst size and operation-mode setting arrive as configuration inputs. Words are fetched from an internal block-RAM style array and presented on the data bus at the programmed edge, one word per clock, with consecutive addresses.

A separate bus-drive enable turns on one clock before the first valid word. It stays on until the cycle after the last word, so the pin driver can be modelled apart from the data-valid strobe. A new accepted read cancels whatever read is still in flight. A read whose latency code or operation mode is not a normal setting is refused and flagged.

A plain write port fills the array. It exists only so that the array has contents; the burst write timing is not part of this block.

Top module: `rdlat_pipe`

## Requirements
- R1: A clock edge with `rst` high clears the pipeline. After that edge `dq_valid`, `dq_oe` and `cfg_err` are low, and any read in progress produces no further words.
- R2: A read accepted at edge n with `cfg_lat` = L (L in 1..3) raises `dq_valid` first after edge n+L, with `dq_out` equal to the array word at `rd_addr`.
- R3: `dq_oe` is high after each edge from n+L-1 through n+L+B-1, where B is the burst size in words. It is low after edge n+L+B. `dq_oe` is high whenever `dq_valid` is high.
- R4: `cfg_burst` codes 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 words. Word k of the burst (k from 0) is presented after edge n+L+k and holds the array word at `rd_addr`+k, wrapping modulo the array depth.
- R5: A read accepted at edge m cancels all earlier reads. From edge m onward `dq_valid` and `dq_oe` follow only the new read and its own latency.
- R6: A read with `cfg_lat` of 0 or 4..7 is refused. `cfg_err` is high for exactly the cycle after that edge, and any read already in flight continues unchanged.
- R7: A read with a nonzero `cfg_opmode` is refused in the same way as R6. Only the all-zero value is normal operation.
- R8: With `mem_we` high at an edge, `mem_wdata` is stored at `mem_addr`, and a later read of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_we | input | 1 | Array write strobe |
| mem_addr | input | ADDR_W | Array write address |
| mem_wdata | input | DATA_W | Array write data |
| rd_valid | input | 1 | Read command registered at this edge |
| rd_addr | input | ADDR_W | Read start address |
| cfg_lat | input | 3 | Read latency in clocks; 1..3 legal |
| cfg_burst | input | 2 | Burst size code: 1 << code words |
| cfg_opmode | input | 3 | Operation mode; zero is normal |
| dq_out | output | DATA_W | Read data; meaningful while dq_valid |
| dq_valid | output | 1 | dq_out holds a burst word |
| dq_oe | output | 1 | Data bus drive enable |
| cfg_err | output | 1 | Pulse: last read command refused |

## Verification
All twelve latency and burst combinations are run from an idle bus. This separates an off-by-one in the delay line, which moves the first word, from a wrong burst count, which moves the last word and the enable drop. A burst that crosses the top of the array checks the address wrap. Truncating reads are issued at several offsets into a burst, including inside the latency wait and with a shorter new latency, so that cancellation is told apart from the two reads overlapping. Refused commands are sent both on an idle bus and in the middle of a burst, which shows that they neither start nor disturb a read, and a constrained-random mix covers interleavings the directed cases miss.

// File: rtl/rdlat_pkg.sv
package rdlat_pkg;
  localparam int LAT_W     = 3;
  localparam int BCODE_W   = 2;
  localparam int OPMODE_W  = 3;
  localparam int MAX_LAT   = 3;
  localparam int MAX_BEATS = 1 << ((1 << BCODE_W) - 1);
  localparam int BEAT_W    = $clog2(MAX_BEATS);
  localparam int WAIT_W    = $clog2(MAX_LAT);

  // legal latency codes are 1..MAX_LAT
  function automatic logic lat_legal(input logic [LAT_W-1:0] lat);
    return (lat >= LAT_W'(1)) && (lat <= LAT_W'(MAX_LAT));
  endfunction

  // index of the final word of a burst selected by code
  function automatic logic [BEAT_W-1:0] last_beat(input logic [BCODE_W-1:0] code);
    logic [BEAT_W:0] words;
    words = {{BEAT_W{1'b0}}, 1'b1} << code;
    return BEAT_W'(words - 1'b1);
  endfunction
endpackage

// File: rtl/rdlat_cmd_dec.sv
module rdlat_cmd_dec
  import rdlat_pkg::*;
(
  input  logic                rd_valid,
  input  logic [LAT_W-1:0]    cfg_lat,
  input  logic [OPMODE_W-1:0] cfg_opmode,
  output logic                accept,
  output logic                reject
);
  logic legal;

  always_comb begin
    legal  = lat_legal(cfg_lat) && (cfg_opmode == '0);
    accept = rd_valid && legal;
    reject = rd_valid && !legal;
  end
endmodule

// File: rtl/rdlat_seq.sv
module rdlat_seq
  import rdlat_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [LAT_W-1:0]   lat,
  input  logic [BCODE_W-1:0] burst_code,
  output logic               fetch_q,
  output logic               fetch_d,
  output logic [ADDR_W-1:0]  fetch_addr,
  output logic               active
);
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic [BEAT_W-1:0] beats_q, beats_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    wait_d  = wait_q;
    beats_d = beats_q;
    addr_d  = addr_q;
    fetch_d = fetch_q;
    if (accept) begin
      addr_d  = start_addr;
      beats_d = last_beat(burst_code);
      if (lat == LAT_W'(1)) begin
        fetch_d = 1'b1;
        wait_d  = '0;
      end else begin
        fetch_d = 1'b0;
        wait_d  = WAIT_W'(lat - LAT_W'(1));
      end
    end else if (wait_q != '0) begin
      wait_d = wait_q - 1'b1;
      if (wait_q == WAIT_W'(1)) fetch_d = 1'b1;
    end else if (fetch_q) begin
      if (beats_q != '0) begin
        beats_d = beats_q - 1'b1;
        addr_d  = ADDR_W'(addr_q + 1'b1);
      end else begin
        fetch_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q  <= '0;
      beats_q <= '0;
      addr_q  <= '0;
      fetch_q <= 1'b0;
    end else begin
      wait_q  <= wait_d;
      beats_q <= beats_d;
      addr_q  <= addr_d;
      fetch_q <= fetch_d;
    end
  end

  assign fetch_addr = addr_q;
  assign active     = fetch_q || (wait_q != '0);
endmodule

// File: rtl/rdlat_store.sv
module rdlat_store #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rdlat_pipe.sv
module rdlat_pipe
  import rdlat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mem_we,
  input  logic [ADDR_W-1:0]   mem_addr,
  input  logic [DATA_W-1:0]   mem_wdata,
  input  logic                rd_valid,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [LAT_W-1:0]    cfg_lat,
  input  logic [BCODE_W-1:0]  cfg_burst,
  input  logic [OPMODE_W-1:0] cfg_opmode,
  output logic [DATA_W-1:0]   dq_out,
  output logic                dq_valid,
  output logic                dq_oe,
  output logic                cfg_err
);
  logic              acc, rej;
  logic              fetch_q, fetch_d, seq_active;
  logic [ADDR_W-1:0] fetch_addr;
  logic              valid_q, oe_q, err_q;

  rdlat_cmd_dec u_dec (
    .rd_valid   (rd_valid),
    .cfg_lat    (cfg_lat),
    .cfg_opmode (cfg_opmode),
    .accept     (acc),
    .reject     (rej)
  );

  rdlat_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .accept     (acc),
    .start_addr (rd_addr),
    .lat        (cfg_lat),
    .burst_code (cfg_burst),
    .fetch_q    (fetch_q),
    .fetch_d    (fetch_d),
    .fetch_addr (fetch_addr),
    .active     (seq_active)
  );

  rdlat_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_wdata),
    .raddr (fetch_addr),
    .rdata (dq_out)
  );

  // a word fetched in the cycle of a new accept is dropped (truncation)
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      oe_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= fetch_q && !acc;
      oe_q    <= fetch_d || (fetch_q && !acc);
      err_q   <= rej;
    end
  end

  assign dq_valid = valid_q;
  assign dq_oe    = oe_q;
  assign cfg_err  = err_q;
endmodule

// File: rtl/rdlat_pipe_chk.sv
module rdlat_pipe_chk
  import rdlat_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             rd_valid,
  input logic [LAT_W-1:0] cfg_lat,
  input logic             acc,
  input logic             seq_active,
  input logic             dq_valid,
  input logic             dq_oe,
  input logic             cfg_err
);
  logic [3:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !dq_valid) run_q <= '0;
    else if (run_q != 4'hF) run_q <= run_q + 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!dq_valid && !dq_oe && !cfg_err));

  assert_no_early_data_R2: assert property (@(posedge clk) disable iff (rst)
    acc |=> !dq_valid);

  assert_valid_has_oe_R3: assert property (@(posedge clk) disable iff (rst)
    dq_valid |-> dq_oe);

  assert_oe_leads_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_valid) |-> $past(dq_oe));

  assert_lat1_oe_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && cfg_lat == LAT_W'(1)) |=> dq_oe);

  assert_burst_cap_R4: assert property (@(posedge clk) disable iff (rst)
    dq_valid |-> (run_q < 4'(MAX_BEATS)));

  assert_err_source_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $past(rd_valid));

  assert_idle_refuse_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !acc && !seq_active && !dq_oe) |=> !dq_oe);
endmodule

bind rdlat_pipe rdlat_pipe_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_valid   (rd_valid),
  .cfg_lat    (cfg_lat),
  .acc        (acc),
  .seq_active (seq_active),
  .dq_valid   (dq_valid),
  .dq_oe      (dq_oe),
  .cfg_err    (cfg_err)
);

// File: tb/rdlat_pipe_tb.sv
module rdlat_pipe_tb;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mem_we = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic [DW-1:0] mem_wdata = '0;
  logic          rd_valid = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [2:0]    cfg_lat = 3'd1;
  logic [1:0]    cfg_burst = '0;
  logic [2:0]    cfg_opmode = '0;
  logic [DW-1:0] dq_out;
  logic          dq_valid, dq_oe, cfg_err;

  rdlat_pipe #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .cfg_lat(cfg_lat), .cfg_burst(cfg_burst), .cfg_opmode(cfg_opmode),
    .dq_out(dq_out), .dq_valid(dq_valid), .dq_oe(dq_oe), .cfg_err(cfg_err)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string sec = "R1";

  // reference model state
  logic [DW-1:0] sh [DEPTH];
  bit have_rd = 1'b0;
  int cyc = 0, m_cyc = 0, m_lat = 0, m_len = 0;
  logic [AW-1:0] m_base = '0;

  function automatic logic [DW-1:0] pattern(input int i);
    return (32'(i) * 32'h0101_0101) ^ 32'hA55A_0000;
  endfunction

  function automatic bit legal_cmd(input logic [2:0] l, input logic [2:0] op);
    return (l >= 3'd1) && (l <= 3'd3) && (op == 3'd0);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // one clock: update model from inputs sampled at the edge, then compare
  task automatic tick();
    bit e_oe, e_v, e_err;
    int d;
    logic [DW-1:0] e_dat;
    @(posedge clk);
    if (mem_we) sh[mem_addr] = mem_wdata;
    e_err = 1'b0;
    if (rst) have_rd = 1'b0;
    else begin
      e_err = rd_valid && !legal_cmd(cfg_lat, cfg_opmode);
      if (rd_valid && legal_cmd(cfg_lat, cfg_opmode)) begin
        have_rd = 1'b1; m_cyc = cyc; m_lat = int'(cfg_lat);
        m_len = 1 << cfg_burst; m_base = rd_addr;
      end
    end
    e_oe = 1'b0; e_v = 1'b0; e_dat = '0;
    if (have_rd) begin
      d = cyc - m_cyc;
      e_oe = (d >= m_lat - 1) && (d <= m_lat + m_len - 1);
      e_v  = (d >= m_lat) && (d <= m_lat + m_len - 1);
      e_dat = sh[AW'(int'(m_base) + d - m_lat)];
    end
    #2;
    check(dq_oe == e_oe, {sec, " R3 oe"}, 32'(dq_oe), 32'(e_oe));
    check(dq_valid == e_v, {sec, " R2 valid"}, 32'(dq_valid), 32'(e_v));
    if (e_v) check(dq_out == e_dat, {sec, " R4 data"}, dq_out, e_dat);
    check(cfg_err == e_err, {sec, " R6 R7 err"}, 32'(cfg_err), 32'(e_err));
    cyc++;
  endtask

  task automatic cyc_in(input bit rv, input int a, input int l, input int b, input int op);
    @(negedge clk);
    rd_valid = rv; rd_addr = AW'(a); cfg_lat = 3'(l);
    cfg_burst = 2'(b); cfg_opmode = 3'(op);
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc_in(0, 0, 1, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: held in reset, even with a read presented
    sec = "R1";
    cyc_in(1, 3, 1, 3, 0);
    cyc_in(0, 0, 1, 0, 0);
    @(negedge clk); rst = 1'b0;
    // R8: fill the array
    sec = "R8";
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      mem_we = 1'b1; mem_addr = AW'(i); mem_wdata = pattern(i);
      tick();
    end
    @(negedge clk); mem_we = 1'b0; tick();
    // R2 R3 R4: every latency and burst from idle
    sec = "R2";
    for (int l = 1; l <= 3; l++)
      for (int b = 0; b < 4; b++) begin
        cyc_in(1, 16 * l + 4 * b, l, b, 0);
        idle(12);
      end
    // R4: wrap at the top of the array
    sec = "R4";
    cyc_in(1, 253, 2, 3, 0); idle(12);
    // R5: truncation at several offsets and latencies
    sec = "R5";
    for (int off = 1; off <= 6; off++) begin
      cyc_in(1, 40, 3, 3, 0); idle(off - 1);
      cyc_in(1, 100, 1 + off % 3, 2, 0); idle(10);
    end
    cyc_in(1, 60, 2, 3, 0); cyc_in(1, 70, 3, 1, 0); idle(10);
    // R6: refused latency codes, idle and mid-burst
    sec = "R6";
    cyc_in(1, 5, 0, 3, 0); idle(4);
    cyc_in(1, 5, 4, 3, 0); idle(4);
    cyc_in(1, 80, 2, 3, 0); idle(3);
    cyc_in(1, 9, 7, 0, 0); idle(10);
    // R7: nonzero operation mode
    sec = "R7";
    cyc_in(1, 5, 2, 2, 1); idle(4);
    cyc_in(1, 90, 1, 3, 0); idle(2);
    cyc_in(1, 5, 1, 1, 4); idle(10);
    // R8: overwrite a word, then read it back
    sec = "R8";
    @(negedge clk); mem_we = 1'b1; mem_addr = 8'd77; mem_wdata = 32'hDEAD_BEEF; tick();
    @(negedge clk); mem_we = 1'b0; tick();
    cyc_in(1, 77, 1, 0, 0); idle(4);
    // R1: reset in the middle of a burst
    sec = "R1";
    cyc_in(1, 20, 1, 3, 0); idle(2);
    @(negedge clk); rst = 1'b1; tick();
    @(negedge clk); rst = 1'b0; tick();
    idle(10);
    // random mix
    sec = "RND";
    for (int i = 0; i < 3000; i++) begin
      int r, l, op;
      r = int'($urandom_range(0, 3));
      l = int'($urandom_range(0, 9));
      l = (l > 4) ? 1 + l % 3 : l;
      op = ($urandom_range(0, 15) == 0) ? int'($urandom_range(1, 7)) : 0;
      cyc_in(r == 0, int'($urandom_range(0, DEPTH - 1)), l,
             int'($urandom_range(0, 3)), op);
    end
    idle(12);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule